// File: doc/BRIEF.md
# Indexed Address Generator Unit

This block forms RAM addresses on behalf of a separate data-path engine, so that address arithmetic never competes with data work. It keeps a small file of address registers. A narrow command interface picks a target register and an operation. The operation can load the register from the shared data bus, step it up or down, form a scaled-indexed address from two registers, or fetch a new register value through memory, which is one level of indirection. The block returns a registered RAM address, a request strobe, a write enable and a transfer size, and it raises one-cycle wrap flags when a counter passes its top or bottom.

The address bus is separate from the data bus. Only LOAD and the second cycle of an indirect fetch read the data bus. Every other command leaves that bus free for RAM data. Every output is registered, so a command sampled at one rising edge shows its effect during the following cycle. A register update made by the same command is visible to a command sampled at the next edge. An indirect fetch spends one extra cycle in a busy state, and any command presented during that cycle is dropped. Reset is asserted asynchronously, and its release is synchronised to the clock with two flops.

Opcode encoding on `cmd_op`: 0 NOP, 1 LOAD, 2 INC, 3 DEC, 4 IDX, 5 INDIRECT; 6 and 7 behave as NOP.

Top module: `addr_gen_unit`

## Requirements
- R1: While reset is applied and after it is released, all address registers read as zero and every output (`mem_addr`, `mem_req`, `mem_we`, `mem_size`, `cnt_ovf`, `cnt_unf`, `busy`) is zero.
- R2: LOAD (op 1) writes `dbus_in[AW-1:0]` into register `cmd_sel`. No RAM request is issued in the following cycle.
- R3: INC (op 2) issues a request at the register's current value and then adds one modulo 2^AW. When the value was all ones, `cnt_ovf` is 1 in the cycle the request is shown.
- R4: DEC (op 3) issues a request at the register's current value and then subtracts one modulo 2^AW. When the value was zero, `cnt_unf` is 1 in the cycle the request is shown.
- R5: IDX (op 4) requests `reg[cmd_sel] + (reg[cmd_isel] << cmd_scale)` modulo 2^AW, with `cmd_scale` 0..3 meaning x1, x2, x4 and x8. It modifies no register, and `cmd_isel` may equal `cmd_sel`.
- R6: For INC, DEC and IDX, the cycle after the command edge shows `mem_req`=1, `mem_we`=`cmd_we` and `mem_size`=`cmd_size` (0 byte, 1 half-word, 2 word). In a cycle without a request, `mem_we`, `mem_size` and `mem_addr` are zero.
- R7: INDIRECT (op 5) shows, in the next cycle, a read (`mem_we`=0, `mem_size`=2) at the register's value with `busy`=1. At the end of that cycle, `dbus_in[AW-1:0]` is written into the register, and `busy` then returns to 0.
- R8: A command presented while `busy` is 1 is ignored. It makes no request and changes no register.
- R9: Opcodes 0, 6 and 7 make no request and change no register.
- R10: `cnt_ovf` and `cnt_unf` are single-cycle pulses and are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Operation code |
| cmd_sel | input | 2 | Target register |
| cmd_isel | input | 2 | Index register for IDX |
| cmd_scale | input | 2 | Index left shift for IDX |
| cmd_we | input | 1 | Write (1) or read (0) for INC, DEC and IDX |
| cmd_size | input | 2 | Transfer size for INC, DEC and IDX |
| dbus_in | input | 32 | Shared data bus |
| mem_addr | output | 20 | RAM address |
| mem_req | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write enable |
| mem_size | output | 2 | RAM transfer size |
| cnt_ovf | output | 1 | Counter wrapped from all ones to zero |
| cnt_unf | output | 1 | Counter wrapped from zero to all ones |
| busy | output | 1 | Indirect fetch in progress; data bus claimed |

## Verification
The bench uses the default parameters: a 20-bit address, a 32-bit data bus, four registers and a 2-bit scale. With a 20-bit width, a single LOAD of 0xFFFFF or 0 places a register at its wrap point, so both flags are reached in a few cycles. With four registers, an index register can be either distinct from the base register or the same one, and the bench covers both cases at every scale. Directed runs through the wraps, every scale, an indirect fetch with a command colliding with it, and the unused opcodes are followed by a long stretch of mixed commands. A behavioural model checks the outputs of every cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LOAD = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_IDX  = 3'd4,
    OP_IND  = 3'd5
  } agu_op_e;

  localparam logic [1:0] XFER_WORD = 2'b10;
endpackage

// File: rtl/agu_rst_sync.sv
module agu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int AW   = 20,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [SW-1:0] rd_a_sel,
  input  logic [SW-1:0] rd_b_sel,
  output logic [AW-1:0] rd_a,
  output logic [AW-1:0] rd_b
);
  logic [AW-1:0] slots [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic          slot_en;
    logic [AW-1:0] slot_q;

    assign slot_en = wr_en && (wr_sel == SW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= wr_data;
      end
    end

    assign slots[g] = slot_q;
  end

  assign rd_a = slots[rd_a_sel];
  assign rd_b = slots[rd_b_sel];
endmodule

// File: rtl/agu_arith.sv
module agu_arith #(
  parameter int AW  = 20,
  parameter int SCW = 2
) (
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  index,
  input  logic [SCW-1:0] scale,
  output logic [AW-1:0]  base_up,
  output logic [AW-1:0]  base_down,
  output logic [AW-1:0]  scaled_addr,
  output logic           base_is_max,
  output logic           base_is_zero
);
  logic [AW-1:0] shifted;

  always_comb begin
    shifted      = index << scale;
    scaled_addr  = base + shifted;
    base_up      = base + AW'(1);
    base_down    = base - AW'(1);
    base_is_max  = &base;
    base_is_zero = ~|base;
  end
endmodule

// File: rtl/agu_ctrl.sv
module agu_ctrl #(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] start_sel,
  output logic          fetching,
  output logic [SW-1:0] fetch_sel
);
  typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} ctrl_state_e;

  ctrl_state_e   state_q, state_d;
  logic [SW-1:0] sel_q;
  logic          sel_en;

  always_comb begin
    state_d = state_q;
    sel_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_FETCH;
          sel_en  = 1'b1;
        end
      end
      ST_FETCH: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= start_sel;
    end
  end

  assign fetching  = (state_q == ST_FETCH);
  assign fetch_sel = sel_q;
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import agu_pkg::*;
#(
  parameter int AW   = 20,
  parameter int DW   = 32,
  parameter int NREG = 4,
  parameter int SCW  = 2,
  localparam int SW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     cmd_op,
  input  logic [SW-1:0]  cmd_sel,
  input  logic [SW-1:0]  cmd_isel,
  input  logic [SCW-1:0] cmd_scale,
  input  logic           cmd_we,
  input  logic [1:0]     cmd_size,
  input  logic [DW-1:0]  dbus_in,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_req,
  output logic           mem_we,
  output logic [1:0]     mem_size,
  output logic           cnt_ovf,
  output logic           cnt_unf,
  output logic           busy
);
  logic          rst_int_n;
  logic [AW-1:0] rd_a, rd_b;
  logic [AW-1:0] val_up, val_down, val_scaled;
  logic          val_max, val_zero;
  logic          fetching;
  logic [SW-1:0] fetch_sel;
  logic          start_fetch;

  logic          wr_en;
  logic [SW-1:0] wr_sel;
  logic [AW-1:0] wr_data;

  logic [AW-1:0] addr_d;
  logic          req_d, we_d, ovf_d, unf_d;
  logic [1:0]    size_d;

  agu_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  agu_regfile #(.AW(AW), .NREG(NREG)) u_regfile (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_a_sel (cmd_sel),
    .rd_b_sel (cmd_isel),
    .rd_a     (rd_a),
    .rd_b     (rd_b)
  );

  agu_arith #(.AW(AW), .SCW(SCW)) u_arith (
    .base         (rd_a),
    .index        (rd_b),
    .scale        (cmd_scale),
    .base_up      (val_up),
    .base_down    (val_down),
    .scaled_addr  (val_scaled),
    .base_is_max  (val_max),
    .base_is_zero (val_zero)
  );

  assign start_fetch = !fetching && (cmd_op == OP_IND);

  agu_ctrl #(.SW(SW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start_fetch),
    .start_sel (cmd_sel),
    .fetching  (fetching),
    .fetch_sel (fetch_sel)
  );

  // Command decode: register write-back and next output values
  always_comb begin
    wr_en   = 1'b0;
    wr_sel  = cmd_sel;
    wr_data = dbus_in[AW-1:0];
    addr_d  = '0;
    req_d   = 1'b0;
    we_d    = 1'b0;
    size_d  = '0;
    ovf_d   = 1'b0;
    unf_d   = 1'b0;
    if (fetching) begin
      wr_en   = 1'b1;
      wr_sel  = fetch_sel;
    end else begin
      case (cmd_op)
        OP_LOAD: wr_en = 1'b1;
        OP_INC: begin
          wr_en   = 1'b1;
          wr_data = val_up;
          addr_d  = rd_a;
          req_d   = 1'b1;
          we_d    = cmd_we;
          size_d  = cmd_size;
          ovf_d   = val_max;
        end
        OP_DEC: begin
          wr_en   = 1'b1;
          wr_data = val_down;
          addr_d  = rd_a;
          req_d   = 1'b1;
          we_d    = cmd_we;
          size_d  = cmd_size;
          unf_d   = val_zero;
        end
        OP_IDX: begin
          addr_d  = val_scaled;
          req_d   = 1'b1;
          we_d    = cmd_we;
          size_d  = cmd_size;
        end
        OP_IND: begin
          addr_d  = rd_a;
          req_d   = 1'b1;
          size_d  = XFER_WORD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mem_addr <= '0;
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      mem_size <= '0;
      cnt_ovf  <= 1'b0;
      cnt_unf  <= 1'b0;
    end else begin
      mem_addr <= addr_d;
      mem_req  <= req_d;
      mem_we   <= we_d;
      mem_size <= size_d;
      cnt_ovf  <= ovf_d;
      cnt_unf  <= unf_d;
    end
  end

  assign busy = fetching;
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [1:0]    mem_size,
  input logic          cnt_ovf,
  input logic          cnt_unf,
  input logic          busy
);
  assert_ovf_at_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ovf |-> (mem_req && (mem_addr == {AW{1'b1}})));

  assert_unf_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_unf |-> (mem_req && (mem_addr == '0)));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (!mem_we && (mem_size == 2'b00) && (mem_addr == '0)));

  assert_fetch_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_req && !mem_we && (mem_size == 2'b10)));

  assert_fetch_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  assert_flags_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_ovf && cnt_unf));
endmodule

bind addr_gen_unit agu_checker #(.AW(AW)) u_agu_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_addr (mem_addr),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_size (mem_size),
  .cnt_ovf  (cnt_ovf),
  .cnt_unf  (cnt_unf),
  .busy     (busy)
);

// File: tb/test_addr_gen_unit.sv
`timescale 1ns/1ps
module test_addr_gen_unit;
  localparam int AW = 20;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [1:0]    cmd_sel = '0, cmd_isel = '0, cmd_scale = '0, cmd_size = '0;
  logic          cmd_we = 1'b0;
  logic [DW-1:0] dbus_in = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_req, mem_we, cnt_ovf, cnt_unf, busy;
  logic [1:0]    mem_size;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  addr_gen_unit i_addr_gen_unit (
    .clk, .rst_n, .cmd_op, .cmd_sel, .cmd_isel, .cmd_scale, .cmd_we,
    .cmd_size, .dbus_in, .mem_addr, .mem_req, .mem_we, .mem_size,
    .cnt_ovf, .cnt_unf, .busy
  );

  // Behavioural reference model
  logic [AW-1:0] m_reg [4];
  bit            m_busy;
  int            m_fsel;
  logic [AW-1:0] e_addr;
  logic          e_req, e_we, e_ovf, e_unf, e_busy;
  logic [1:0]    e_size;
  string         e_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = '0;
      m_busy = 0; m_fsel = 0;
      e_addr = '0; e_req = 0; e_we = 0; e_size = 0; e_ovf = 0; e_unf = 0; e_busy = 0;
      e_tag = "R1";
    end else begin
      e_addr = '0; e_req = 0; e_we = 0; e_size = 0; e_ovf = 0; e_unf = 0;
      if (m_busy) begin
        m_reg[m_fsel] = dbus_in[AW-1:0];
        m_busy = 0;
        e_tag = (cmd_op != 0) ? "R8" : "R7";
      end else begin
        case (cmd_op)
          3'd1: begin m_reg[cmd_sel] = dbus_in[AW-1:0]; e_tag = "R2"; end
          3'd2: begin
            e_addr = m_reg[cmd_sel]; e_req = 1; e_we = cmd_we; e_size = cmd_size;
            e_ovf = (m_reg[cmd_sel] == {AW{1'b1}});
            m_reg[cmd_sel] = m_reg[cmd_sel] + 1;
            e_tag = "R3 R6 R10";
          end
          3'd3: begin
            e_addr = m_reg[cmd_sel]; e_req = 1; e_we = cmd_we; e_size = cmd_size;
            e_unf = (m_reg[cmd_sel] == '0);
            m_reg[cmd_sel] = m_reg[cmd_sel] - 1;
            e_tag = "R4 R6 R10";
          end
          3'd4: begin
            e_addr = m_reg[cmd_sel] + (m_reg[cmd_isel] << cmd_scale);
            e_req = 1; e_we = cmd_we; e_size = cmd_size;
            e_tag = "R5 R6";
          end
          3'd5: begin
            e_addr = m_reg[cmd_sel]; e_req = 1; e_size = 2'd2;
            m_busy = 1; m_fsel = int'(cmd_sel);
            e_tag = "R7";
          end
          default: e_tag = "R9";
        endcase
      end
      e_busy = m_busy;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      tests++;
      if ({mem_addr, mem_req, mem_we, mem_size, cnt_ovf, cnt_unf, busy} !==
          {e_addr, e_req, e_we, e_size, e_ovf, e_unf, e_busy}) begin
        fails++;
        $display("FAIL %s at %0t: addr=%h req=%b we=%b size=%0d ovf=%b unf=%b busy=%b expected addr=%h req=%b we=%b size=%0d ovf=%b unf=%b busy=%b",
                 e_tag, $time, mem_addr, mem_req, mem_we, mem_size, cnt_ovf, cnt_unf, busy,
                 e_addr, e_req, e_we, e_size, e_ovf, e_unf, e_busy);
      end
    end
  end

  task automatic cmd(input logic [2:0] op, input logic [1:0] sel, input logic [1:0] isel,
                     input logic [1:0] sc, input logic we, input logic [1:0] sz,
                     input logic [DW-1:0] d);
    @(negedge clk);
    cmd_op = op; cmd_sel = sel; cmd_isel = isel; cmd_scale = sc;
    cmd_we = we; cmd_size = sz; dbus_in = d;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    tests++;
    if ({mem_addr, mem_req, mem_we, mem_size, cnt_ovf, cnt_unf, busy} !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs: got %h expected 0",
               {mem_addr, mem_req, mem_we, mem_size, cnt_ovf, cnt_unf, busy});
    end
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (4) cmd(3'd0, 0, 0, 0, 0, 0, '0);
    // R1: all registers zero after reset, read through INC
    for (int r = 0; r < 4; r++) cmd(3'd2, 2'(r), 0, 0, 0, 2'd2, '0);
    // R3 overflow wrap
    cmd(3'd1, 0, 0, 0, 0, 0, 32'h000F_FFFF);
    cmd(3'd2, 0, 0, 0, 1, 2'd0, '0);
    cmd(3'd2, 0, 0, 0, 0, 2'd1, '0);
    cmd(3'd0, 0, 0, 0, 0, 0, '0);
    // R4 underflow wrap
    cmd(3'd1, 1, 0, 0, 0, 0, 32'hABC0_0000);
    cmd(3'd3, 1, 0, 0, 1, 2'd1, '0);
    cmd(3'd3, 1, 0, 0, 0, 2'd2, '0);
    // R5 scaled index at every scale, plus aliasing
    cmd(3'd1, 2, 0, 0, 0, 0, 32'h0000_0100);
    cmd(3'd1, 3, 0, 0, 0, 0, 32'h0000_0003);
    for (int s = 0; s < 4; s++) cmd(3'd4, 2, 3, 2'(s), 1'(s & 1), 2'd2, '0);
    cmd(3'd4, 3, 3, 2'd1, 0, 2'd0, '0);
    // R7 indirect, R8 colliding command dropped
    cmd(3'd5, 2, 0, 0, 1, 2'd0, 32'h5555_5555);
    cmd(3'd2, 0, 0, 0, 1, 2'd1, 32'h000A_BCDE);
    cmd(3'd2, 2, 0, 0, 0, 2'd2, '0);
    cmd(3'd2, 0, 0, 0, 0, 2'd2, '0);
    // R9 unused opcodes
    cmd(3'd6, 1, 0, 0, 1, 2'd3, 32'h1234_5678);
    cmd(3'd7, 1, 0, 0, 1, 2'd3, 32'h1234_5678);
    cmd(3'd0, 1, 0, 0, 1, 2'd3, 32'h1234_5678);
    cmd(3'd2, 1, 0, 0, 0, 2'd2, '0);
    // Mixed traffic with frequent wrap points
    for (int n = 0; n < 4000; n++) begin
      logic [DW-1:0] d;
      case ($urandom_range(0, 3))
        0: d = 32'hFFFF_FFFF;
        1: d = '0;
        default: d = $urandom;
      endcase
      cmd(3'($urandom_range(0, 7)), 2'($urandom), 2'($urandom), 2'($urandom),
          1'($urandom), 2'($urandom), d);
    end
    cmd(3'd0, 0, 0, 0, 0, 0, '0);
    @(negedge clk);
    summary();
  end
endmodule